// File: doc/BRIEF.md
# Serial Channel Command Strobe Controller

This block takes one-shot commands that a host writes into a single 8-bit register and carries them across to the clock domain of an asynchronous serial channel. The host side latches the live command bits, flips a request toggle and shows a busy flag. The channel side synchronises the toggle, executes every command bit of the write in one cycle and returns an acknowledge toggle. The busy flag falls when that acknowledge has come back. A write that arrives while busy is set is thrown away and raises a sticky lost flag.

On the channel side the block does the bookkeeping for the receive buffer. It counts stored bytes and cuts them into blocks, either at a fill threshold, at an end-of-data indication, or early on a host request. Space is freed only when the host confirms that it has taken the block. For transmission the block starts the shifter with a byte count. In interrupt mode that count is the number of bytes loaded into the transmit buffer. In DMA mode it is a 12-bit count programmed beforehand. The block also gives the channel timer a start pulse and keeps a running flag for it. Shifter, DMA engine and timer logic sit outside and connect only through strobes.

Top module: `sercmd_ctrl`

## Requirements
- R1: After reset every output is 0: busy, lost, occupancy, byte count, all strobes, interrupts, DMA request, transmit length and the timer running flag.
- R2: A write with at least one live bit (bits 5:0) is accepted when busy is clear. Its commands act on the channel state at the third channel edge after the accepting host edge. `cmd_busy` is high from the accepting edge until the fifth host edge after it, when both clocks run at the same rate.
- R3: A write that arrives while `cmd_busy` is high is discarded and sets `cmd_lost`. `cmd_lost` stays set until reset.
- R4: Bits 7 and 6 have no effect. A write that has no live bit neither starts a command nor raises busy.
- R5: `rx_occ` goes up by one for each `rx_wr` while below RX_DEPTH and saturates there. It goes down only by the length of the pending block, when the release command (bit 5) executes with a block pending.
- R6: Only one block is pending at a time. With no block pending, a block of the current occupancy forms in one of two ways. Early read (bit 4 clear, bit 3 set) or `rx_end` with a nonzero count forms it with a `rx_tc_irq` pulse. Otherwise, occupancy at or above RX_THRESH forms it with a `rx_blk_irq` pulse. `rx_byte_cnt` holds the block length. Release clears the pending block.
- R7: `rx_dma_req` is high when `dma_mode` is set, a block is pending and no `rx_dma_done` has been seen for that block. After `rx_dma_done` it stays low until release or receiver reset.
- R8: Receiver reset (bit 4) clears occupancy, the pending block, the byte count and the DMA lock, and pulses `rx_rst_o`. In the same write it overrides release and early read.
- R9: Transmit start (bit 0) pulses `tx_go` and sets `tx_len`. In interrupt mode `tx_len` is the count of `tx_wr` bytes since the last start or transmit reset, saturating at TX_DEPTH. In DMA mode it is `{xbc_hi, xbc_lo}`. The loaded count restarts from the byte written in that cycle.
- R10: Transmit reset (bit 1) clears the loaded count and pulses `tx_rst_o`. In the same write it suppresses transmit start.
- R11: Timer start (bit 2) pulses `timer_go` and sets `timer_run`. `tmr_wr` clears `timer_run`, but a start in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst_n | input | 1 | Host domain reset, active low |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | 8 | Command bits: 0 tx start, 1 tx reset, 2 timer start, 3 early read, 4 rx reset, 5 release |
| cmd_busy | output | 1 | Command in flight |
| cmd_lost | output | 1 | Sticky: a write arrived while busy |
| cclk | input | 1 | Channel clock |
| crst_n | input | 1 | Channel domain reset, active low |
| dma_mode | input | 1 | 1 = DMA mode, 0 = interrupt mode |
| rx_wr | input | 1 | Receiver stored one byte |
| rx_end | input | 1 | Receive end condition |
| rx_dma_done | input | 1 | DMA transfer of the pending block complete |
| tx_wr | input | 1 | Host loaded one transmit byte |
| tmr_wr | input | 1 | Timer register rewritten |
| xbc_hi | input | XBC_HI_W | DMA transmit count, high part |
| xbc_lo | input | 8 | DMA transmit count, low part |
| rx_occ | output | OCC_W | Receive bytes held |
| rx_byte_cnt | output | OCC_W | Length of pending block |
| rx_blk_irq | output | 1 | Threshold block ready pulse |
| rx_tc_irq | output | 1 | Transfer-complete pulse (early read or end) |
| rx_dma_req | output | 1 | Receive DMA request |
| rx_rst_o | output | 1 | Receiver reset strobe |
| tx_go | output | 1 | Transmit start strobe |
| tx_len | output | XBC_HI_W+8 | Bytes to send |
| tx_rst_o | output | 1 | Transmitter reset strobe |
| timer_go | output | 1 | Timer start strobe |
| timer_run | output | 1 | Timer running |

## Verification
The hardest cases are those where a command's execution edge falls on the same edge as a channel-side event. Examples are a timer start meeting `tmr_wr`, or a release meeting a saturated buffer that forms the next block at once. Another is a second write landing inside the busy window. The bench ties both clocks together, so execution falls on a known edge three cycles after the write. It then places `tmr_wr`, back-to-back writes and overflowing byte bursts on exactly those edges. A behavioural model, stepped on every edge, predicts each output.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

  typedef struct packed {
    logic spare7;
    logic spare6;
    logic rx_release;
    logic rx_reset;
    logic rx_early;
    logic tmr_start;
    logic tx_reset;
    logic tx_frame;
  } cmd_t;

  localparam logic [7:0] CMD_LIVE_MASK = 8'h3F;

  // occupancy after freeing a block and maybe storing a byte (room judged before the release)
  function automatic int occ_next(int occ, int freed, logic wr, int depth);
    return occ - freed + ((wr && occ < depth) ? 1 : 0);
  endfunction

  function automatic int fill_next(int fill, logic wr, int depth);
    return (wr && fill < depth) ? fill + 1 : fill;
  endfunction

  function automatic int dma_count(int hi, int lo);
    return hi * 256 + lo;
  endfunction

endpackage

// File: rtl/sercmd_host.sv
module sercmd_host
  import sercmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       ack_tgl,
  output logic       req_tgl,
  output cmd_t       cmd_q,
  output logic       busy,
  output logic       lost,
  output logic       accept
);
  logic ack_s1, ack_s2;

  assign busy   = req_tgl ^ ack_s2;
  assign accept = wr_en && !busy && ((wr_data & CMD_LIVE_MASK) != 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s1  <= 1'b0;
      ack_s2  <= 1'b0;
      req_tgl <= 1'b0;
      cmd_q   <= '0;
      lost    <= 1'b0;
    end else begin
      ack_s1 <= ack_tgl;
      ack_s2 <= ack_s1;
      if (accept) begin
        cmd_q   <= cmd_t'(wr_data & CMD_LIVE_MASK);
        req_tgl <= ~req_tgl;
      end
      if (wr_en && busy) lost <= 1'b1;
    end
  end
endmodule

// File: rtl/sercmd_xfer.sv
module sercmd_xfer (
  input  logic clk,
  input  logic rst_n,
  input  logic req_tgl,
  output logic fire,
  output logic ack_tgl
);
  logic s1, s2, s3;

  assign fire    = s2 ^ s3;
  assign ack_tgl = s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= req_tgl;
      s2 <= s1;
      s3 <= s2;
    end
  end
endmodule

// File: rtl/sercmd_rx.sv
module sercmd_rx
  import sercmd_pkg::*;
#(
  parameter int RX_DEPTH  = 32,
  parameter int RX_THRESH = 16,
  localparam int OCC_W    = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_mode,
  input  logic             rx_wr,
  input  logic             rx_end,
  input  logic             rx_dma_done,
  input  logic             ev_rmc,
  input  logic             ev_rrst,
  input  logic             ev_rfrd,
  output logic [OCC_W-1:0] rx_occ,
  output logic [OCC_W-1:0] rx_byte_cnt,
  output logic             rx_blk_irq,
  output logic             rx_tc_irq,
  output logic             rx_dma_req,
  output logic             rx_rst_o
);
  logic             blk_pend, dma_lock;
  logic [OCC_W-1:0] blk_len, freed;
  logic             form_tc, form_thr, form;

  assign form_tc     = ev_rfrd || (rx_end && rx_occ != '0);
  assign form_thr    = rx_occ >= OCC_W'(RX_THRESH);
  assign form        = !blk_pend && (form_tc || form_thr);
  assign freed       = (ev_rmc && blk_pend) ? blk_len : '0;
  assign rx_dma_req  = dma_mode && blk_pend && !dma_lock;
  assign rx_byte_cnt = blk_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_occ     <= '0;
      blk_len    <= '0;
      blk_pend   <= 1'b0;
      dma_lock   <= 1'b0;
      rx_blk_irq <= 1'b0;
      rx_tc_irq  <= 1'b0;
      rx_rst_o   <= 1'b0;
    end else begin
      rx_rst_o   <= ev_rrst;
      rx_blk_irq <= 1'b0;
      rx_tc_irq  <= 1'b0;
      if (ev_rrst) begin
        rx_occ   <= '0;
        blk_len  <= '0;
        blk_pend <= 1'b0;
        dma_lock <= 1'b0;
      end else begin
        rx_occ <= OCC_W'(occ_next(int'(rx_occ), int'(freed), rx_wr, RX_DEPTH));
        if (blk_pend) begin
          if (ev_rmc) begin
            blk_pend <= 1'b0;
            dma_lock <= 1'b0;
          end else if (rx_dma_done) begin
            dma_lock <= 1'b1;
          end
        end else if (form) begin
          blk_pend   <= 1'b1;
          blk_len    <= rx_occ;
          rx_tc_irq  <= form_tc;
          rx_blk_irq <= !form_tc;
        end
      end
    end
  end
endmodule

// File: rtl/sercmd_tx.sv
module sercmd_tx
  import sercmd_pkg::*;
#(
  parameter int TX_DEPTH  = 32,
  parameter int XBC_HI_W  = 4,
  localparam int FILL_W   = $clog2(TX_DEPTH + 1),
  localparam int LEN_W    = XBC_HI_W + 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dma_mode,
  input  logic                tx_wr,
  input  logic [XBC_HI_W-1:0] xbc_hi,
  input  logic [7:0]          xbc_lo,
  input  logic                tmr_wr,
  input  logic                ev_xf,
  input  logic                ev_xres,
  input  logic                ev_tgo,
  output logic                tx_go,
  output logic [LEN_W-1:0]    tx_len,
  output logic                tx_rst_o,
  output logic                timer_go,
  output logic                timer_run
);
  logic [FILL_W-1:0] fill;
  logic [LEN_W-1:0]  start_len;

  always_comb begin
    if (dma_mode) start_len = LEN_W'(dma_count(int'(xbc_hi), int'(xbc_lo)));
    else          start_len = LEN_W'(fill);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill      <= '0;
      tx_go     <= 1'b0;
      tx_len    <= '0;
      tx_rst_o  <= 1'b0;
      timer_go  <= 1'b0;
      timer_run <= 1'b0;
    end else begin
      tx_go    <= ev_xf;
      tx_rst_o <= ev_xres;
      timer_go <= ev_tgo;
      if (ev_xres)    fill <= '0;
      else if (ev_xf) fill <= FILL_W'(fill_next(0, tx_wr, TX_DEPTH));
      else            fill <= FILL_W'(fill_next(int'(fill), tx_wr, TX_DEPTH));
      if (ev_xf) tx_len <= start_len;
      if (ev_tgo)      timer_run <= 1'b1;
      else if (tmr_wr) timer_run <= 1'b0;
    end
  end
endmodule

// File: rtl/sercmd_ctrl.sv
module sercmd_ctrl
  import sercmd_pkg::*;
#(
  parameter int RX_DEPTH  = 32,
  parameter int RX_THRESH = 16,
  parameter int TX_DEPTH  = 32,
  parameter int XBC_HI_W  = 4,
  localparam int OCC_W    = $clog2(RX_DEPTH + 1),
  localparam int LEN_W    = XBC_HI_W + 8
) (
  input  logic                hclk,
  input  logic                hrst_n,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  output logic                cmd_busy,
  output logic                cmd_lost,
  input  logic                cclk,
  input  logic                crst_n,
  input  logic                dma_mode,
  input  logic                rx_wr,
  input  logic                rx_end,
  input  logic                rx_dma_done,
  input  logic                tx_wr,
  input  logic                tmr_wr,
  input  logic [XBC_HI_W-1:0] xbc_hi,
  input  logic [7:0]          xbc_lo,
  output logic [OCC_W-1:0]    rx_occ,
  output logic [OCC_W-1:0]    rx_byte_cnt,
  output logic                rx_blk_irq,
  output logic                rx_tc_irq,
  output logic                rx_dma_req,
  output logic                rx_rst_o,
  output logic                tx_go,
  output logic [LEN_W-1:0]    tx_len,
  output logic                tx_rst_o,
  output logic                timer_go,
  output logic                timer_run
);
  logic req_tgl, ack_tgl, fire, wr_accept;
  cmd_t cmd_q, exec_cmd;
  logic ev_rmc, ev_rrst, ev_rfrd, ev_xf, ev_xres, ev_tgo;

  sercmd_host u_host (
    .clk(hclk), .rst_n(hrst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ack_tgl(ack_tgl), .req_tgl(req_tgl), .cmd_q(cmd_q),
    .busy(cmd_busy), .lost(cmd_lost), .accept(wr_accept)
  );

  sercmd_xfer u_xfer (
    .clk(cclk), .rst_n(crst_n), .req_tgl(req_tgl), .fire(fire), .ack_tgl(ack_tgl)
  );

  // cmd_q is held stable while the request is in flight, so the channel side may read it
  assign exec_cmd = fire ? cmd_q : '0;
  assign ev_rrst  = exec_cmd.rx_reset;
  assign ev_rmc   = exec_cmd.rx_release && !exec_cmd.rx_reset;
  assign ev_rfrd  = exec_cmd.rx_early   && !exec_cmd.rx_reset;
  assign ev_xres  = exec_cmd.tx_reset;
  assign ev_xf    = exec_cmd.tx_frame   && !exec_cmd.tx_reset;
  assign ev_tgo   = exec_cmd.tmr_start;

  sercmd_rx #(.RX_DEPTH(RX_DEPTH), .RX_THRESH(RX_THRESH)) u_rx (
    .clk(cclk), .rst_n(crst_n), .dma_mode(dma_mode), .rx_wr(rx_wr),
    .rx_end(rx_end), .rx_dma_done(rx_dma_done),
    .ev_rmc(ev_rmc), .ev_rrst(ev_rrst), .ev_rfrd(ev_rfrd),
    .rx_occ(rx_occ), .rx_byte_cnt(rx_byte_cnt), .rx_blk_irq(rx_blk_irq),
    .rx_tc_irq(rx_tc_irq), .rx_dma_req(rx_dma_req), .rx_rst_o(rx_rst_o)
  );

  sercmd_tx #(.TX_DEPTH(TX_DEPTH), .XBC_HI_W(XBC_HI_W)) u_tx (
    .clk(cclk), .rst_n(crst_n), .dma_mode(dma_mode), .tx_wr(tx_wr),
    .xbc_hi(xbc_hi), .xbc_lo(xbc_lo), .tmr_wr(tmr_wr),
    .ev_xf(ev_xf), .ev_xres(ev_xres), .ev_tgo(ev_tgo),
    .tx_go(tx_go), .tx_len(tx_len), .tx_rst_o(tx_rst_o),
    .timer_go(timer_go), .timer_run(timer_run)
  );
endmodule

// File: rtl/sercmd_ctrl_chk.sv
module sercmd_ctrl_chk #(
  parameter int RX_DEPTH = 32,
  localparam int OCC_W   = $clog2(RX_DEPTH + 1)
) (
  input logic             hclk,
  input logic             hrst_n,
  input logic             cclk,
  input logic             crst_n,
  input logic             wr_accept,
  input logic             cmd_busy,
  input logic             cmd_lost,
  input logic [OCC_W-1:0] rx_occ,
  input logic             ev_rmc,
  input logic             ev_rrst,
  input logic             rx_blk_irq,
  input logic             rx_tc_irq,
  input logic             rx_dma_done,
  input logic             rx_dma_req,
  input logic             tx_go,
  input logic             tx_rst_o,
  input logic             timer_go,
  input logic             timer_run
);
  p_busy_on_accept_r2: assert property (@(posedge hclk) disable iff (!hrst_n)
    wr_accept |=> cmd_busy);

  p_lost_sticky_r3: assert property (@(posedge hclk) disable iff (!hrst_n)
    cmd_lost |=> cmd_lost);

  p_occ_bound_r5: assert property (@(posedge cclk) disable iff (!crst_n)
    rx_occ <= OCC_W'(RX_DEPTH));

  p_occ_no_drop_r5: assert property (@(posedge cclk) disable iff (!crst_n)
    (!ev_rmc && !ev_rrst) |=> rx_occ >= $past(rx_occ));

  p_irq_excl_r6: assert property (@(posedge cclk) disable iff (!crst_n)
    !(rx_blk_irq && rx_tc_irq));

  p_dma_quiet_r7: assert property (@(posedge cclk) disable iff (!crst_n)
    (rx_dma_done && rx_dma_req) |=> !rx_dma_req);

  p_rx_reset_r8: assert property (@(posedge cclk) disable iff (!crst_n)
    ev_rrst |=> (rx_occ == '0) && !rx_dma_req);

  p_tx_excl_r10: assert property (@(posedge cclk) disable iff (!crst_n)
    !(tx_go && tx_rst_o));

  p_timer_run_r11: assert property (@(posedge cclk) disable iff (!crst_n)
    timer_go |-> timer_run);
endmodule

bind sercmd_ctrl sercmd_ctrl_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (
  .hclk(hclk), .hrst_n(hrst_n), .cclk(cclk), .crst_n(crst_n),
  .wr_accept(wr_accept), .cmd_busy(cmd_busy), .cmd_lost(cmd_lost),
  .rx_occ(rx_occ), .ev_rmc(ev_rmc), .ev_rrst(ev_rrst),
  .rx_blk_irq(rx_blk_irq), .rx_tc_irq(rx_tc_irq),
  .rx_dma_done(rx_dma_done), .rx_dma_req(rx_dma_req),
  .tx_go(tx_go), .tx_rst_o(tx_rst_o), .timer_go(timer_go), .timer_run(timer_run)
);

// File: tb/sercmd_ctrl_bench.sv
`timescale 1ns/1ps
module sercmd_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       wr_en = 0, dma_mode = 0, rx_wr = 0, rx_end = 0, rx_dma_done = 0;
  logic       tx_wr = 0, tmr_wr = 0;
  logic [7:0] wr_data = 0, xbc_lo = 0;
  logic [3:0] xbc_hi = 0;
  logic       cmd_busy, cmd_lost, rx_blk_irq, rx_tc_irq, rx_dma_req, rx_rst_o;
  logic       tx_go, tx_rst_o, timer_go, timer_run;
  logic [5:0] rx_occ, rx_byte_cnt;
  logic [11:0] tx_len;

  sercmd_ctrl u_sercmd_ctrl (
    .hclk(clk), .hrst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_busy(cmd_busy), .cmd_lost(cmd_lost),
    .cclk(clk), .crst_n(rst_n), .dma_mode(dma_mode), .rx_wr(rx_wr),
    .rx_end(rx_end), .rx_dma_done(rx_dma_done), .tx_wr(tx_wr), .tmr_wr(tmr_wr),
    .xbc_hi(xbc_hi), .xbc_lo(xbc_lo), .rx_occ(rx_occ), .rx_byte_cnt(rx_byte_cnt),
    .rx_blk_irq(rx_blk_irq), .rx_tc_irq(rx_tc_irq), .rx_dma_req(rx_dma_req),
    .rx_rst_o(rx_rst_o), .tx_go(tx_go), .tx_len(tx_len), .tx_rst_o(tx_rst_o),
    .timer_go(timer_go), .timer_run(timer_run)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // behavioural reference model, stepped on every clock edge
  int m_bcnt = 0, m_ecnt = 0, m_cmd = 0, m_lost = 0;
  int m_occ = 0, m_pend = 0, m_blen = 0, m_lock = 0, m_blk = 0, m_tc = 0, m_rrst = 0;
  int m_fill = 0, m_go = 0, m_len = 0, m_xrst = 0, m_tgo = 0, m_trun = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bcnt = 0; m_ecnt = 0; m_cmd = 0; m_lost = 0;
      m_occ = 0; m_pend = 0; m_blen = 0; m_lock = 0; m_blk = 0; m_tc = 0; m_rrst = 0;
      m_fill = 0; m_go = 0; m_len = 0; m_xrst = 0; m_tgo = 0; m_trun = 0;
    end else begin
      bit was_busy, exe, rrst, rel, early, xres, xf, tst, tc_cause;
      int c, gone;
      was_busy = (m_bcnt > 0);
      exe = 0;
      if (m_ecnt > 0) begin m_ecnt--; exe = (m_ecnt == 0); end
      if (m_bcnt > 0) m_bcnt--;
      c = exe ? m_cmd : 0;
      rrst = c[4]; rel = c[5] && !rrst; early = c[3] && !rrst;
      xres = c[1]; xf = c[0] && !xres; tst = c[2];
      m_blk = 0; m_tc = 0; m_rrst = rrst;
      if (rrst) begin
        m_occ = 0; m_pend = 0; m_blen = 0; m_lock = 0;
      end else begin
        gone = (rel && m_pend) ? m_blen : 0;
        tc_cause = early || (rx_end && m_occ != 0);
        if (m_pend) begin
          if (rel) begin m_pend = 0; m_lock = 0; end
          else if (rx_dma_done) m_lock = 1;
          m_occ = m_occ - gone + ((rx_wr && m_occ < 32) ? 1 : 0);
        end else begin
          if (tc_cause || m_occ >= 16) begin
            m_pend = 1; m_blen = m_occ; m_tc = tc_cause; m_blk = !tc_cause;
          end
          m_occ = m_occ + ((rx_wr && m_occ < 32) ? 1 : 0);
        end
      end
      m_go = xf; m_xrst = xres; m_tgo = tst;
      if (xf) m_len = dma_mode ? (xbc_hi * 256 + xbc_lo) : m_fill;
      if (xres) m_fill = 0;
      else if (xf) m_fill = tx_wr ? 1 : 0;
      else if (tx_wr && m_fill < 32) m_fill++;
      if (tst) m_trun = 1; else if (tmr_wr) m_trun = 0;
      if (wr_en) begin
        if (was_busy) m_lost = 1;
        else if ((wr_data & 8'h3F) != 0) begin
          m_cmd = wr_data & 8'h3F; m_ecnt = 3; m_bcnt = 5;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 cmd_busy", cmd_busy, m_bcnt > 0);
      chk("R3 cmd_lost", cmd_lost, m_lost);
      chk("R5 rx_occ", rx_occ, m_occ);
      chk("R6 rx_byte_cnt", rx_byte_cnt, m_blen);
      chk("R6 rx_blk_irq", rx_blk_irq, m_blk);
      chk("R6 rx_tc_irq", rx_tc_irq, m_tc);
      chk("R7 rx_dma_req", rx_dma_req, dma_mode && m_pend && !m_lock);
      chk("R8 rx_rst_o", rx_rst_o, m_rrst);
      chk("R9 tx_go", tx_go, m_go);
      chk("R9 tx_len", tx_len, m_len);
      chk("R10 tx_rst_o", tx_rst_o, m_xrst);
      chk("R11 timer_go", timer_go, m_tgo);
      chk("R11 timer_run", timer_run, m_trun);
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic write(input logic [7:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0; wr_data = 0;
  endtask
  task automatic cmd(input logic [7:0] d); write(d); repeat (6) tick(); endtask
  task automatic rx_bytes(input int n);
    for (int i = 0; i < n; i++) begin rx_wr = 1; tick(); end
    rx_wr = 0;
  endtask
  task automatic tx_bytes(input int n);
    for (int i = 0; i < n; i++) begin tx_wr = 1; tick(); end
    tx_wr = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1: idle state after reset
    chk("R1 busy", cmd_busy, 0);   chk("R1 lost", cmd_lost, 0);
    chk("R1 occ", rx_occ, 0);      chk("R1 txlen", tx_len, 0);
    chk("R1 run", timer_run, 0);   chk("R1 dmareq", rx_dma_req, 0);
    // R4: only unused bits set
    write(8'hC0);
    chk("R4 busy after spare-only write", cmd_busy, 0);
    repeat (6) tick();
    chk("R4 no timer", timer_run, 0);
    // R11 timer start then stop
    cmd(8'h04);
    chk("R11 running", timer_run, 1);
    tmr_wr = 1; tick(); tmr_wr = 0; tick();
    chk("R11 stopped", timer_run, 0);
    // R9 interrupt mode and DMA mode starts
    tx_bytes(5); cmd(8'h01);
    chk("R9 int len", tx_len, 5);
    dma_mode = 1; xbc_hi = 4'h3; xbc_lo = 8'h2A; cmd(8'h01);
    chk("R9 dma len", tx_len, 12'h32A);
    dma_mode = 0;
    // R10 reset beats start, then start with zero loaded
    tx_bytes(3); cmd(8'h03); cmd(8'h01);
    chk("R10 len after reset", tx_len, 0);
    // R5/R6 threshold block, release, end block, early read
    rx_bytes(20); repeat (2) tick();
    chk("R6 byte count", rx_byte_cnt, 16);
    cmd(8'h20);
    chk("R5 after release", rx_occ, 4);
    rx_end = 1; tick(); rx_end = 0; tick();
    chk("R6 end block", rx_byte_cnt, 4);
    cmd(8'h20);
    rx_bytes(2); cmd(8'h08);
    chk("R6 early block", rx_byte_cnt, 2);
    cmd(8'h20);
    // R5 saturation, chained blocks
    rx_bytes(40);
    chk("R5 saturated", rx_occ, 32);
    cmd(8'h20); cmd(8'h20);
    chk("R5 drained", rx_occ, 0);
    // R7 DMA request and lock
    dma_mode = 1; rx_bytes(16); repeat (3) tick();
    chk("R7 req up", rx_dma_req, 1);
    rx_dma_done = 1; tick(); rx_dma_done = 0; tick();
    chk("R7 req held low", rx_dma_req, 0);
    cmd(8'h20); dma_mode = 0;
    // R3 write while busy
    write(8'h04); write(8'h01);
    chk("R3 lost set", cmd_lost, 1);
    repeat (8) tick();
    // R8 reset overrides release
    rx_bytes(5); cmd(8'h08); cmd(8'h30);
    chk("R8 occ cleared", rx_occ, 0);
    // R11 start wins over stop on the execution edge; R9 with R11 in one write
    write(8'h04); tick(); tick(); tmr_wr = 1; tick(); tmr_wr = 0;
    chk("R11 start wins", timer_run, 1);
    repeat (4) tick();
    tx_bytes(2); cmd(8'h05);
    chk("R9 combined len", tx_len, 2);
    // rx_end and early read landing on a pending block, release with writes in flight
    rx_bytes(17); rx_end = 1; cmd(8'h08); rx_end = 0;
    rx_wr = 1; cmd(8'h20); rx_wr = 0;
    repeat (4) tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      done = 1;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule